// File: doc/BRIEF.md
# Sampling-Delay Tuning Window Search

This block finds a safe sampling delay for a high-speed read path. After a start request it sweeps the delay tap upward from zero through a fixed usable range. At each tap it applies the tap through a request/acknowledge handshake, then asks an external checker whether a tuning transfer at that tap passed. While sweeping it keeps the longest run of consecutive passing taps. At the end it applies the tap at the centre of that run and reports done. If no tap passed, it reports an error instead.

The tuning transfer and its data comparison are outside the block. They appear only as the check request/result handshake. A tap whose apply is not acknowledged within a short cycle budget counts as a failing tap. Only the lower part of the tap field's range is swept, because the upper codes are unreliable.

Top module: `tap_window_tuner`

## Requirements
- R1: After an accepted start, taps 0, 1, …, TAP_COUNT-1 are each applied exactly once, in ascending order. The tap value is presented on `applyTap` while `applyReq` is high.
- R2: `applyReq` stays high until `applyAck` is sampled high, and drops on the following cycle. `checkReq` is raised only after the current tap's apply was acknowledged. It is never high together with `applyReq`, and it stays high until `checkValid` is sampled high.
- R3: A tap apply is acknowledged if `applyAck` is high in any of the first APPLY_TIMEOUT cycles of its request. An acknowledge in the last of those cycles still counts. If no acknowledge arrives in that window, the tap counts as failed, no check is requested for it, and the sweep moves on.
- R4: A tap passes when it was acknowledged and `checkPass` is 1 with `checkValid`. A passing tap extends the current run by one. A failing tap sets the current run to zero.
- R5: The best run is replaced only when the current run becomes strictly longer than it. Among runs of equal length, the earliest one wins.
- R6: When at least one tap passed, the final tap is the last tap of the best run minus floor(best length / 2). It is applied with the same handshake and the same timeout as a sweep tap.
- R7: When no tap passed, `error` is raised and no final apply request is issued.
- R8: `busy` is high from the cycle after an accepted start until the cycle in which `done` or `error` rises. `done` rises only after the final apply is acknowledged. `done` and `error` hold their value until the next accepted start, and they are never both high.
- R9: A start request while `busy` is high is ignored. The sweep and the outcome are unchanged by it.
- R10: If the final apply is not acknowledged within APPLY_TIMEOUT cycles, `error` is raised and `done` stays low.
- R11: After reset, `busy`, `done`, `error`, `applyReq` and `checkReq` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a tuning sweep (accepted only when idle) |
| busy | output | 1 | Sweep or final apply in progress |
| done | output | 1 | Final tap applied successfully; held until next start |
| error | output | 1 | No passing tap or final apply stalled; held until next start |
| applyReq | output | 1 | Delay apply request, held until acknowledged or timed out |
| applyTap | output | TAP_W | Delay tap value to apply |
| applyAck | input | 1 | Apply completed (update flag cleared) |
| checkReq | output | 1 | Request a pass/fail tuning check at the applied tap |
| checkValid | input | 1 | Check result is valid this cycle |
| checkPass | input | 1 | Check result: 1 = pass, 0 = fail |

## Verification
The bench builds the block with a 4-bit tap field, a 10-tap sweep range and an apply timeout of 4 cycles. With these values every one of the 1024 pass/fail patterns across the range can be run, so all run lengths, ties between equal runs, and runs touching either end of the range are covered. The expected centre is computed arithmetically for each pattern. Acknowledge and check latencies are varied across runs, and the acknowledge delay is pushed to the last accepted cycle and one cycle past it. Further runs cover stalled taps mixed into the pattern, a stalled final apply, and a start pulse issued mid-sweep.

// File: rtl/tap_tuner_pkg.sv
package tap_tuner_pkg;

  typedef struct packed {
    logic clear;        // new sweep: reset taps and run records
    logic tapPass;      // current tap passed
    logic tapFail;      // current tap failed (check or apply timeout)
    logic advance;      // move to the next tap
    logic selectFinal;  // latch centre tap and present it
  } tunerStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_APPLY,
    ST_CHECK,
    ST_DECIDE,
    ST_FINAL
  } tunerState_t;

endpackage

// File: rtl/tuner_datapath.sv
module tuner_datapath
  import tap_tuner_pkg::*;
#(
  parameter int TAP_W     = 6,
  parameter int TAP_COUNT = 40
) (
  input  logic             clk,
  input  logic             rstN,
  input  tunerStrobes_t    strb,
  output logic [TAP_W-1:0] applyTap,
  output logic             lastTap,
  output logic             anyPass
);

  localparam int RUN_W = $clog2(TAP_COUNT + 1);
  localparam logic [TAP_W-1:0] LAST_TAP = TAP_W'(TAP_COUNT - 1);

  logic [TAP_W-1:0] curTap;
  logic [TAP_W-1:0] bestEnd;
  logic [TAP_W-1:0] finalTap;
  logic [RUN_W-1:0] curRun;
  logic [RUN_W-1:0] bestRun;
  logic [RUN_W-1:0] runNext;
  logic             finalMode;

  assign runNext = curRun + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curTap    <= '0;
      curRun    <= '0;
      bestRun   <= '0;
      bestEnd   <= '0;
      finalTap  <= '0;
      finalMode <= 1'b0;
    end else if (strb.clear) begin
      curTap    <= '0;
      curRun    <= '0;
      bestRun   <= '0;
      bestEnd   <= '0;
      finalMode <= 1'b0;
    end else begin
      if (strb.tapPass) begin
        curRun <= runNext;
        if (runNext > bestRun) begin
          bestRun <= runNext;
          bestEnd <= curTap;
        end
      end else if (strb.tapFail) begin
        curRun <= '0;
      end
      if (strb.advance) curTap <= curTap + 1'b1;
      if (strb.selectFinal) begin
        finalMode <= 1'b1;
        finalTap  <= bestEnd - TAP_W'(bestRun >> 1);
      end
    end
  end

  assign applyTap = finalMode ? finalTap : curTap;
  assign lastTap  = (curTap == LAST_TAP);
  assign anyPass  = (bestRun != '0);

  a_r1_tap_in_range: assert property (@(posedge clk) disable iff (!rstN)
    curTap <= LAST_TAP);

  a_r4_fail_clears_run: assert property (@(posedge clk) disable iff (!rstN)
    strb.tapFail |=> (curRun == '0));

  a_r5_best_covers_current: assert property (@(posedge clk) disable iff (!rstN)
    bestRun >= curRun);

  a_r5_best_never_shrinks: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clear |=> bestRun >= $past(bestRun));

endmodule

// File: rtl/tuner_control.sv
module tuner_control
  import tap_tuner_pkg::*;
#(
  parameter int APPLY_TIMEOUT = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          applyAck,
  input  logic          checkValid,
  input  logic          checkPass,
  input  logic          lastTap,
  input  logic          anyPass,
  output tunerStrobes_t strb,
  output logic          busy,
  output logic          done,
  output logic          error,
  output logic          applyReq,
  output logic          checkReq
);

  localparam int TMR_W = (APPLY_TIMEOUT > 1) ? $clog2(APPLY_TIMEOUT) : 1;
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(APPLY_TIMEOUT - 1);

  tunerState_t state, nextState;
  logic [TMR_W-1:0] timer;
  logic timedOut;
  logic setDone, setErr;

  assign timedOut = (timer == TMR_LAST);

  always_comb begin
    nextState = state;
    strb      = '0;
    setDone   = 1'b0;
    setErr    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strb.clear = 1'b1;
          nextState  = ST_APPLY;
        end
      end
      ST_APPLY: begin
        if (applyAck) begin
          nextState = ST_CHECK;
        end else if (timedOut) begin
          strb.tapFail = 1'b1;
          if (lastTap) nextState = ST_DECIDE;
          else strb.advance = 1'b1;
        end
      end
      ST_CHECK: begin
        if (checkValid) begin
          strb.tapPass = checkPass;
          strb.tapFail = !checkPass;
          if (lastTap) begin
            nextState = ST_DECIDE;
          end else begin
            strb.advance = 1'b1;
            nextState    = ST_APPLY;
          end
        end
      end
      ST_DECIDE: begin
        if (anyPass) begin
          strb.selectFinal = 1'b1;
          nextState        = ST_FINAL;
        end else begin
          setErr    = 1'b1;
          nextState = ST_IDLE;
        end
      end
      ST_FINAL: begin
        if (applyAck) begin
          setDone   = 1'b1;
          nextState = ST_IDLE;
        end else if (timedOut) begin
          setErr    = 1'b1;
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      timer <= '0;
      done  <= 1'b0;
      error <= 1'b0;
    end else begin
      state <= nextState;
      timer <= ((nextState != state) || strb.advance) ? '0 : timer + 1'b1;
      if (strb.clear) begin
        done  <= 1'b0;
        error <= 1'b0;
      end else begin
        if (setDone) done <= 1'b1;
        if (setErr) error <= 1'b1;
      end
    end
  end

  assign busy     = (state != ST_IDLE);
  assign applyReq = (state == ST_APPLY) || (state == ST_FINAL);
  assign checkReq = (state == ST_CHECK);

  a_r2_req_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(applyReq && checkReq));

  a_r2_release_on_ack: assert property (@(posedge clk) disable iff (!rstN)
    (applyReq && applyAck) |=> !applyReq);

  a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    !(done && busy) && !(done && error));

  a_r8_busy_ends_reported: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (done || error));

endmodule

// File: rtl/tap_window_tuner.sv
module tap_window_tuner
  import tap_tuner_pkg::*;
#(
  parameter int TAP_W         = 6,
  parameter int TAP_COUNT     = 40,
  parameter int APPLY_TIMEOUT = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic             error,
  output logic             applyReq,
  output logic [TAP_W-1:0] applyTap,
  input  logic             applyAck,
  output logic             checkReq,
  input  logic             checkValid,
  input  logic             checkPass
);

  tunerStrobes_t strb;
  logic lastTap;
  logic anyPass;

  tuner_control #(.APPLY_TIMEOUT(APPLY_TIMEOUT)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .applyAck  (applyAck),
    .checkValid(checkValid),
    .checkPass (checkPass),
    .lastTap   (lastTap),
    .anyPass   (anyPass),
    .strb      (strb),
    .busy      (busy),
    .done      (done),
    .error     (error),
    .applyReq  (applyReq),
    .checkReq  (checkReq)
  );

  tuner_datapath #(.TAP_W(TAP_W), .TAP_COUNT(TAP_COUNT)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .applyTap(applyTap),
    .lastTap (lastTap),
    .anyPass (anyPass)
  );

endmodule

// File: tb/tap_window_tuner_test.sv
module tap_window_tuner_test;

  localparam int TW = 4;
  localparam int TC = 10;
  localparam int TO = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, start, busy, done, error, applyReq, applyAck, checkReq, checkValid, checkPass;
  logic [TW-1:0] applyTap;

  tap_window_tuner #(.TAP_W(TW), .TAP_COUNT(TC), .APPLY_TIMEOUT(TO)) uut (
    .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done), .error(error),
    .applyReq(applyReq), .applyTap(applyTap), .applyAck(applyAck),
    .checkReq(checkReq), .checkValid(checkValid), .checkPass(checkPass)
  );

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // responder state
  logic [TC-1:0] passMask, stallMask;
  bit finalStall;
  int ackLat, checkLat;
  int epi, reqCycles, chkCycles;
  bit prevReq, acked, stallNow, finalSeen;
  logic [TW-1:0] prevTap;
  int orderErrs, hsErrs, finalTapSeen;

  always @(negedge clk) begin
    applyAck   = 1'b0;
    checkValid = 1'b0;
    checkPass  = 1'b0;
    if (applyReq) begin
      if (!prevReq || applyTap != prevTap) begin
        epi++;
        reqCycles = 0;
        acked = 1'b0;
        if (epi < TC && applyTap != TW'(epi)) orderErrs++;
        if (epi == TC) begin
          finalSeen = 1'b1;
          finalTapSeen = int'(applyTap);
        end
        if (epi > TC) orderErrs++;
      end
      stallNow = (epi < TC) ? stallMask[epi] : finalStall;
      if (!stallNow && reqCycles == ackLat) begin
        applyAck = 1'b1;
        acked = 1'b1;
      end
      reqCycles++;
    end
    if (checkReq) begin
      if (!acked || applyReq || epi < 0 || epi >= TC) begin
        hsErrs++;
      end else begin
        if (chkCycles == checkLat) begin
          checkValid = 1'b1;
          checkPass  = passMask[epi];
        end
        chkCycles++;
      end
    end else begin
      chkCycles = 0;
    end
    prevReq = applyReq;
    prevTap = applyTap;
  end

  // global watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic runOne(input logic [TC-1:0] pm, input logic [TC-1:0] sm, input bit fs,
                        input int al, input int cl, input bit poke);
    int cur, best, bestEndI, expTap, w;
    bit expDone, expErr;
    passMask = pm; stallMask = sm; finalStall = fs; ackLat = al; checkLat = cl;
    epi = -1; finalSeen = 1'b0; orderErrs = 0; hsErrs = 0; prevReq = 1'b0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(busy == 1'b1, "R8 busy after start", int'(busy), 1);
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
      check(busy == 1'b1, "R9 busy kept after start while busy", int'(busy), 1);
    end
    w = 0;
    while (busy && w < 2000) begin
      @(negedge clk);
      w++;
    end
    check(w < 2000, "R8 run completes", w, 0);
    // expected model (R4, R5)
    cur = 0; best = 0; bestEndI = 0;
    for (int i = 0; i < TC; i++) begin
      if (pm[i] && !sm[i] && al < TO) begin
        cur++;
        if (cur > best) begin
          best = cur;
          bestEndI = i;
        end
      end else begin
        cur = 0;
      end
    end
    expTap  = bestEndI - best / 2;
    expErr  = (best == 0) || fs;
    expDone = !expErr;
    check(orderErrs == 0 && (epi >= TC - 1), "R1 sweep order", orderErrs, 0);
    check(hsErrs == 0, "R2,R3 check only after acknowledged apply", hsErrs, 0);
    check(done == expDone, "R8,R10 done", int'(done), int'(expDone));
    check(error == expErr, "R7,R10 error", int'(error), int'(expErr));
    if (best == 0) begin
      check(!finalSeen, "R7 no final apply", int'(finalSeen), 0);
    end else begin
      check(finalSeen && finalTapSeen == expTap, "R4,R5,R6 final centre tap",
            finalSeen ? finalTapSeen : -1, expTap);
    end
  endtask

  initial begin
    rstN = 1'b0;
    start = 1'b0;
    applyAck = 1'b0;
    checkValid = 1'b0;
    checkPass = 1'b0;
    passMask = '0; stallMask = '0; finalStall = 1'b0;
    ackLat = 0; checkLat = 0; epi = -1; reqCycles = 0; chkCycles = 0;
    prevReq = 1'b0; prevTap = '0; acked = 1'b0; stallNow = 1'b0; finalSeen = 1'b0;
    orderErrs = 0; hsErrs = 0; finalTapSeen = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check({busy, done, error, applyReq, checkReq} == 5'b0, "R11 reset outputs",
          int'({busy, done, error, applyReq, checkReq}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check({busy, done, error, applyReq, checkReq} == 5'b0, "R11 idle after reset",
          int'({busy, done, error, applyReq, checkReq}), 0);

    // exhaustive pass patterns with varied latencies (R1, R4, R5, R6, R7)
    for (int p = 0; p < (1 << TC); p++) begin
      runOne(TC'(p), '0, 1'b0, p % 3, (p / 3) % 2, 1'b0);
    end

    // stalled taps mixed in (R3)
    for (int s = 0; s < 64; s++) begin
      runOne(TC'((1 << TC) - 1) ^ TC'(s * 13), TC'((s * 151) % (1 << TC)), 1'b0, 1, s % 2, 1'b0);
    end

    // timeout boundary: ack in the last allowed cycle still accepted (R3)
    runOne('1, '0, 1'b0, TO - 1, 0, 1'b0);
    // one cycle late: every tap fails, error (R3, R7)
    runOne('1, '0, 1'b0, TO, 0, 1'b0);
    // stalled final apply (R10)
    runOne(TC'(10'b0011110000), '0, 1'b1, 0, 0, 1'b0);
    // done held until next start (R8)
    runOne(TC'(10'b0000111000), '0, 1'b0, 1, 1, 1'b0);
    repeat (5) @(negedge clk);
    check(done == 1'b1 && busy == 1'b0, "R8 done held while idle", int'(done), 1);
    // start while busy ignored (R9)
    runOne(TC'(10'b0111100110), '0, 1'b0, 1, 1, 1'b1);
    runOne(TC'(10'b1100000011), '0, 1'b0, 2, 0, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule